// File: doc/BRIEF.md
# Cycle Performance Counter Bank with Negative-Value Alert

The block holds six 32-bit performance counters, a 64-bit monitor control register and one event selector per counter. On each cycle in which the cycle event input is high, every counter that is set to count cycles and is not frozen advances by one. Whether a counter counts cycles depends on two things: its position in the bank and the code in its selector.

The alert reports that an armed counter has gone negative, which means its bit 31 is set. Counter 1 has its own alert enable. Counters 2 to 6 share a second enable. When the alert fires, the block sets the global freeze bit, which stops all six counters, and it raises the alert output. The alert output stays high until software writes the control register with the global freeze bit clear.

Software reaches every register through a single write port and a combinational read port. Control register bit numbers below are LSB-0 indices into the 64-bit word.

Top module: `pmc_bank`

## Requirements
- R1: After reset, the control register, all counters and all selectors read zero, and the alert output is low.
- R2: Counter 1 advances on a cycle event when its selector holds 0xF0 or 0x1E and it is not frozen.
- R3: Counters 2, 3 and 4 advance on cycle events only when their selector holds 0x1E. A selector of 0xF0 leaves them still.
- R4: Counter 6 advances on every unfrozen cycle event, whatever its selector holds. Counter 5 never advances on its own.
- R5: Control bit 5 freezes counters 1 to 4. Control bit 4 freezes counters 5 and 6. Control bit 31 (global freeze) freezes all six.
- R6: Control bit 15 arms the alert for counter 1. Control bit 14 arms it for counters 2 to 6. With both bits clear, no counter value raises the alert.
- R7: When an increment sets bit 31 of an armed, unfrozen counter, the same clock edge stores the value 0x8000_0000 in that counter, sets control bit 31 and raises the alert.
- R8: An armed, unfrozen counter whose bit 31 is already set raises the alert on the next clock edge. No increment is needed.
- R9: A frozen counter never raises the alert, even when it is armed and negative.
- R10: The alert stays high until a control write has bit 31 clear. That write's edge drops the alert, unless a new alert fires on the same edge.
- R11: A counter write takes priority over that counter's increment in the same cycle. The written value is readable in the next cycle. An alert that fires on the same edge as a control write keeps bit 31 set and the alert high.
- R12: Register map on the 4-bit address: 0 is control, 1 to 6 are counters 1 to 6, and 9 to 14 are the 8-bit selectors for counters 1 to 6. Any other address reads zero, and narrow registers read zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_tick_i | input | 1 | Cycle event, one count per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 64 | Write data (low bits used for narrow registers) |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 64 | Read data, combinational |
| alert_o | output | 1 | Negative-value alert, held high until cleared |

## Verification
Two things can fall in one cycle: a software control write that clears the global freeze bit, and an alert trigger from a counter stepping from 0x7FFF_FFFF to 0x8000_0000. The bench provokes this by arming counter 6 and loading it one below the sign boundary. It then issues the control write in the same cycle as the final cycle event. The expected result is that the alert stays high and the control register reads back with bit 31 set. A second collision, a counter write landing in the same cycle as an increment of that counter, is judged by reading back the written value. The behavioural model in the bench is compared against the design every clock.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int CTRL_W   = 64;
    localparam int NCTR     = 6;

    // Control bit indices, LSB-0
    localparam int FRZ_ALL_BIT  = CTRL_W - 1 - 32;
    localparam int EN_FIRST_BIT = CTRL_W - 1 - 48;
    localparam int EN_REST_BIT  = CTRL_W - 1 - 49;
    localparam int FRZ_LO_BIT   = CTRL_W - 1 - 58;
    localparam int FRZ_HI_BIT   = CTRL_W - 1 - 59;

    // Counters below this index belong to the low freeze group
    localparam int LO_GROUP_N   = 4;

    localparam logic [7:0] EVT_CYC_ANY   = 8'h1E;
    localparam logic [7:0] EVT_CYC_FIRST = 8'hF0;

    localparam int ADDR_CTRL     = 0;
    localparam int ADDR_CTR_BASE = 1;
    localparam int ADDR_SEL_BASE = 9;

endpackage

// File: rtl/pmc_cycle_src.sv
module pmc_cycle_src
    import pmc_pkg::*;
#(
    parameter int IDX   = 0,
    parameter int EVT_W = 8
) (
    input  logic [EVT_W-1:0] sel_i,
    output logic             is_cyc_o
);
    localparam bit USE_FIRST = (IDX == 0);
    localparam bit USE_ANY   = (IDX < LO_GROUP_N);
    localparam bit ALWAYS_ON = (IDX == NCTR - 1);

    logic m_first;
    logic m_any;

    assign m_first  = (sel_i == EVT_W'(EVT_CYC_FIRST));
    assign m_any    = (sel_i == EVT_W'(EVT_CYC_ANY));
    assign is_cyc_o = ALWAYS_ON | (USE_FIRST & m_first) | (USE_ANY & m_any);
endmodule

// File: rtl/pmc_ctr_slice.sv
module pmc_ctr_slice #(
    parameter int IDX   = 0,
    parameter int CTR_W = 32,
    parameter int EVT_W = 8
) (
    input  logic [CTR_W-1:0] cnt_q_i,
    input  logic [EVT_W-1:0] sel_q_i,
    input  logic             tick_i,
    input  logic             frozen_i,
    input  logic             armed_i,
    input  logic             wr_hit_i,
    input  logic [CTR_W-1:0] wr_val_i,
    output logic [CTR_W-1:0] cnt_d_o,
    output logic             trig_o
);
    localparam logic [CTR_W-1:0] EDGE_VAL = {1'b0, {(CTR_W-1){1'b1}}};

    logic is_cyc;
    logic inc;
    logic crossing;

    pmc_cycle_src #(.IDX(IDX), .EVT_W(EVT_W)) u_src (
        .sel_i    (sel_q_i),
        .is_cyc_o (is_cyc)
    );

    assign inc      = tick_i & is_cyc & ~frozen_i;
    assign crossing = inc & ~wr_hit_i & (cnt_q_i == EDGE_VAL);

    always_comb begin
        if (wr_hit_i) begin
            cnt_d_o = wr_val_i;
        end else begin
            cnt_d_o = cnt_q_i + {{(CTR_W-1){1'b0}}, inc};
        end
    end

    assign trig_o = armed_i & ~frozen_i & (cnt_q_i[CTR_W-1] | crossing);
endmodule

// File: rtl/pmc_rd_mux.sv
module pmc_rd_mux
    import pmc_pkg::*;
#(
    parameter int CTR_W  = 32,
    parameter int EVT_W  = 8,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0]           rd_addr_i,
    input  logic [CTRL_W-1:0]           ctrl_i,
    input  logic [NCTR-1:0][CTR_W-1:0]  cnt_i,
    input  logic [NCTR-1:0][EVT_W-1:0]  sel_i,
    output logic [CTRL_W-1:0]           rd_data_o
);
    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == ADDR_W'(ADDR_CTRL)) begin
            rd_data_o = ctrl_i;
        end
        for (int k = 0; k < NCTR; k++) begin
            if (rd_addr_i == ADDR_W'(ADDR_CTR_BASE + k)) begin
                rd_data_o = CTRL_W'(cnt_i[k]);
            end
            if (rd_addr_i == ADDR_W'(ADDR_SEL_BASE + k)) begin
                rd_data_o = CTRL_W'(sel_i[k]);
            end
        end
    end
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
    import pmc_pkg::*;
#(
    parameter int CTR_W  = 32,
    parameter int EVT_W  = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cyc_tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [63:0]       wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [63:0]       rd_data_o,
    output logic              alert_o
);
    typedef struct packed {
        logic [CTRL_W-1:0]          ctrl;
        logic [NCTR-1:0][CTR_W-1:0] cnt;
        logic [NCTR-1:0][EVT_W-1:0] sel;
        logic                       alert;
    } state_t;

    state_t st_d, st_q;

    logic [NCTR-1:0]            frz;
    logic [NCTR-1:0]            armed;
    logic [NCTR-1:0]            cnt_hit;
    logic [NCTR-1:0]            trig;
    logic [NCTR-1:0][CTR_W-1:0] cnt_nx;
    logic                       ctrl_hit;
    logic                       trig_any;

    assign ctrl_hit = wr_en_i & (wr_addr_i == ADDR_W'(ADDR_CTRL));
    assign trig_any = |trig;

    for (genvar k = 0; k < NCTR; k++) begin : g_slice
        if (k < LO_GROUP_N) begin : g_lo
            assign frz[k] = st_q.ctrl[FRZ_ALL_BIT] | st_q.ctrl[FRZ_LO_BIT];
        end else begin : g_hi
            assign frz[k] = st_q.ctrl[FRZ_ALL_BIT] | st_q.ctrl[FRZ_HI_BIT];
        end
        if (k == 0) begin : g_first
            assign armed[k] = st_q.ctrl[EN_FIRST_BIT];
        end else begin : g_rest
            assign armed[k] = st_q.ctrl[EN_REST_BIT];
        end
        assign cnt_hit[k] = wr_en_i & (wr_addr_i == ADDR_W'(ADDR_CTR_BASE + k));

        pmc_ctr_slice #(.IDX(k), .CTR_W(CTR_W), .EVT_W(EVT_W)) u_slice (
            .cnt_q_i  (st_q.cnt[k]),
            .sel_q_i  (st_q.sel[k]),
            .tick_i   (cyc_tick_i),
            .frozen_i (frz[k]),
            .armed_i  (armed[k]),
            .wr_hit_i (cnt_hit[k]),
            .wr_val_i (wr_data_i[CTR_W-1:0]),
            .cnt_d_o  (cnt_nx[k]),
            .trig_o   (trig[k])
        );

        // R5 / R9: a frozen counter holds unless software writes it
        p_frozen_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (frz[k] && !cnt_hit[k]) |=> $stable(st_q.cnt[k]));
    end

    always_comb begin
        st_d     = st_q;
        st_d.cnt = cnt_nx;
        for (int k = 0; k < NCTR; k++) begin
            if (wr_en_i && wr_addr_i == ADDR_W'(ADDR_SEL_BASE + k)) begin
                st_d.sel[k] = wr_data_i[EVT_W-1:0];
            end
        end
        if (ctrl_hit) begin
            st_d.ctrl = wr_data_i[CTRL_W-1:0];
            if (!wr_data_i[FRZ_ALL_BIT]) begin
                st_d.alert = 1'b0;
            end
        end
        if (trig_any) begin
            st_d.ctrl[FRZ_ALL_BIT] = 1'b1;
            st_d.alert             = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    pmc_rd_mux #(.CTR_W(CTR_W), .EVT_W(EVT_W), .ADDR_W(ADDR_W)) u_rd (
        .rd_addr_i (rd_addr_i),
        .ctrl_i    (st_q.ctrl),
        .cnt_i     (st_q.cnt),
        .sel_i     (st_q.sel),
        .rd_data_o (rd_data_o)
    );

    assign alert_o = st_q.alert;

    // R7: a raised alert always comes with the global freeze set
    p_alert_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.alert |-> st_q.ctrl[FRZ_ALL_BIT]);

    // R6: with both enables clear, a quiet alert stays quiet
    p_no_enable_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!st_q.ctrl[EN_FIRST_BIT] && !st_q.ctrl[EN_REST_BIT] && !st_q.alert) |=> !st_q.alert);

    // R4: counter 5 only changes through a software write
    p_ctr5_still_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cnt_hit[4] |=> $stable(st_q.cnt[4]));

    // R10: an unfreezing control write with no new trigger drops the alert
    p_unfreeze_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_hit && !wr_data_i[FRZ_ALL_BIT] && !trig_any) |=> !alert_o);
endmodule

// File: tb/pmc_bank_tb_top.sv
module pmc_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [63:0] rd_data;
    logic        alert;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    pmc_bank dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .cyc_tick_i (tick),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .alert_o    (alert)
    );

    // ---------------- behavioural reference ----------------
    logic [63:0] m_ctrl;
    logic [31:0] m_cnt [6];
    logic [7:0]  m_sel [6];
    logic        m_alert;

    function automatic bit counts_cycles(int idx, logic [7:0] code);
        if (idx == 5) return 1'b1;
        if (idx == 4) return 1'b0;
        if (code == 8'h1E) return 1'b1;
        return (idx == 0) && (code == 8'hF0);
    endfunction

    function automatic bit m_frozen(int idx);
        if (m_ctrl[31]) return 1'b1;
        return (idx < 4) ? m_ctrl[5] : m_ctrl[4];
    endfunction

    function automatic logic [63:0] m_read(logic [3:0] a);
        if (a == 0) return m_ctrl;
        if (a >= 1 && a <= 6) return {32'h0, m_cnt[a-1]};
        if (a >= 9 && a <= 14) return {56'h0, m_sel[a-9]};
        return 64'h0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = '0;
            m_alert = 1'b0;
            for (int i = 0; i < 6; i++) begin
                m_cnt[i] = '0;
                m_sel[i] = '0;
            end
        end else begin
            bit fire;
            logic [31:0] nxt [6];
            fire = 1'b0;
            for (int i = 0; i < 6; i++) begin
                bit step, hit, arm;
                hit  = wr_en && (wr_addr == 4'(i + 1));
                step = tick && counts_cycles(i, m_sel[i]) && !m_frozen(i);
                arm  = (i == 0) ? m_ctrl[15] : m_ctrl[14];
                if (arm && !m_frozen(i) &&
                    (m_cnt[i] >= 32'h8000_0000 || (step && !hit && m_cnt[i] == 32'h7FFF_FFFF)))
                    fire = 1'b1;
                nxt[i] = hit ? wr_data[31:0] : (step ? m_cnt[i] + 1 : m_cnt[i]);
            end
            for (int i = 0; i < 6; i++) begin
                m_cnt[i] = nxt[i];
                if (wr_en && wr_addr == 4'(i + 9)) m_sel[i] = wr_data[7:0];
            end
            if (wr_en && wr_addr == 0) begin
                m_ctrl = wr_data;
                if (!wr_data[31]) m_alert = 1'b0;
            end
            if (fire) begin
                m_ctrl[31] = 1'b1;
                m_alert = 1'b1;
            end
        end
    end

    // every-clock comparison against the reference
    always @(posedge clk) begin
        #2;
        cycles++;
        if (rst_n) begin
            checks++;
            if (alert !== m_alert) begin
                errors++;
                $display("FAIL R7 cycle %0d alert got %0b exp %0b", cycles, alert, m_alert);
            end
            checks++;
            if (rd_data !== m_read(rd_addr)) begin
                errors++;
                $display("FAIL %s cycle %0d addr %0d got %h exp %h",
                         (rd_addr == 0) ? "R10" : (rd_addr <= 6) ? "R2" : "R12",
                         cycles, rd_addr, rd_data, m_read(rd_addr));
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic drive(input logic t, input logic we, input logic [3:0] a, input logic [63:0] d);
        @(negedge clk);
        tick = t; wr_en = we; wr_addr = a; wr_data = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 4'h0, 64'h0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 4'h0, 64'h0);
    endtask

    task automatic wr(input logic [3:0] a, input logic [63:0] d);
        drive(1'b0, 1'b1, a, d);
    endtask

    task automatic chk_rd(input logic [3:0] a, input logic [63:0] exp, input string tag);
        drive(1'b0, 1'b0, 4'h0, 64'h0);
        rd_addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s addr %0d got %h exp %h", tag, a, rd_data, exp);
        end
    endtask

    task automatic chk_alert(input logic exp, input string tag);
        #1;
        checks++;
        if (alert !== exp) begin
            errors++;
            $display("FAIL %s alert got %0b exp %0b", tag, alert, exp);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        wait (cycles > 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- directed sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 16; a++) chk_rd(4'(a), 64'h0, "R1");
        chk_alert(1'b0, "R1");

        // R2 R3 R4: cycle sources by index and code
        wr(4'd9, 64'hF0); wr(4'd10, 64'hF0); wr(4'd11, 64'h1E);
        wr(4'd13, 64'h1E); wr(4'd14, 64'h00);
        ticks(10);
        chk_rd(4'd1, 64'd10, "R2");
        chk_rd(4'd2, 64'd0,  "R3");
        chk_rd(4'd3, 64'd10, "R3");
        chk_rd(4'd4, 64'd0,  "R3");
        chk_rd(4'd5, 64'd0,  "R4");
        chk_rd(4'd6, 64'd10, "R4");

        // R5: group and global freezes
        wr(4'd0, 64'h20); ticks(5);
        chk_rd(4'd1, 64'd10, "R5");
        chk_rd(4'd6, 64'd15, "R5");
        wr(4'd0, 64'h10); ticks(5);
        chk_rd(4'd1, 64'd15, "R5");
        chk_rd(4'd6, 64'd15, "R5");
        wr(4'd0, 64'h8000_0000); ticks(3);
        chk_rd(4'd1, 64'd15, "R5");
        chk_rd(4'd6, 64'd15, "R5");

        // R7: increment across the sign boundary
        wr(4'd1, 64'h7FFF_FFFE);
        wr(4'd0, 64'h8000);
        ticks(3);
        chk_alert(1'b1, "R7");
        chk_rd(4'd1, 64'h8000_0000, "R7");
        chk_rd(4'd6, 64'd17, "R7");
        chk_rd(4'd0, 64'h8000_8000, "R7");

        // R10: held while freeze stays set, cleared by an unfreezing write
        wr(4'd0, 64'h8000_8000); idle(1);
        chk_alert(1'b1, "R10");
        wr(4'd0, 64'h0); idle(1);
        chk_alert(1'b0, "R10");

        // R6: no enable, negative counter, no alert
        ticks(3);
        chk_alert(1'b0, "R6");
        chk_rd(4'd1, 64'h8000_0003, "R6");

        // R8: already negative when armed
        wr(4'd0, 64'h8000); idle(2);
        chk_alert(1'b1, "R8");
        chk_rd(4'd0, 64'h8000_8000, "R8");

        // R9: frozen counter is not eligible
        wr(4'd0, 64'h8020); idle(3);
        chk_alert(1'b0, "R9");

        // R6: shared enable covers counter 5
        wr(4'd5, 64'h8000_0000); idle(2);
        chk_alert(1'b0, "R6");
        wr(4'd0, 64'h4020); idle(2);
        chk_alert(1'b1, "R6");
        chk_rd(4'd5, 64'h8000_0000, "R4");

        // R11: trigger and unfreezing write on the same edge
        wr(4'd0, 64'h0);
        wr(4'd5, 64'h0);
        wr(4'd6, 64'h7FFF_FFFF);
        wr(4'd0, 64'h4000);
        idle(1);
        chk_alert(1'b0, "R11");
        drive(1'b1, 1'b1, 4'd0, 64'h4000);
        idle(1);
        chk_alert(1'b1, "R11");
        chk_rd(4'd0, 64'h8000_4000, "R11");
        chk_rd(4'd6, 64'h8000_0000, "R11");

        // R11: counter write beats increment
        wr(4'd0, 64'h0);
        drive(1'b1, 1'b1, 4'd6, 64'd5);
        chk_rd(4'd6, 64'd5, "R11");

        // R12: map holes and zero extension
        chk_rd(4'd7,  64'h0,  "R12");
        chk_rd(4'd8,  64'h0,  "R12");
        chk_rd(4'd15, 64'h0,  "R12");
        chk_rd(4'd9,  64'hF0, "R12");

        idle(2);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule